// File: doc/BRIEF.md
# Two-Group Coincidence Trigger

This block turns a bus of raw detector signals into a single coincidence trigger. Each signal first passes through its own polarity stage, which a per-bit invert mask controls. Two enable masks then select two groups of signals. The selected signals in each group are ORed into one group hit. A trigger pulse is issued when both groups have produced a hit within a short, fixed window of each other. At the 200 MHz target clock this window is 40 ns, which is 8 cycles.

At build time the input stage is either a plain OR of levels or an edge detector. In edge mode, a new transition on any enabled input counts as a fresh hit even while other inputs of the same group are still high. A small register port lets software write the invert mask and the two group masks and read them back. The same port also reads a fixed configuration word that describes how the block was built.

Top module: `coinc_trigger`

## Requirements
- R1: After reset the invert mask and both group masks are zero, register reads return zero, and the trigger output is low.
- R2: The invert mask is at offset 0x24, the group-A mask at 0x25 and the group-B mask at 0x26. All three are read/write. Read data is valid in the cycle after the clock edge that samples the read strobe, and it is zero in any cycle without a read.
- R3: Offset 0x27 is a read-only configuration word. Bits 5:0 hold the number of inputs, bits 11:8 hold the number of outputs (1), and bits 19:16 hold the stage code: 1 for level/OR, 2 for edge detect. All other bits are zero, and writes to this offset change nothing.
- R4: A read of any offset other than 0x24 to 0x27 returns zero.
- R5: Bit i of the invert mask flips input i before any trigger logic. With the bit set, a falling input counts as a rising hit.
- R6: A group hit is the OR of that group's enabled, polarity-corrected inputs. A group whose mask is all zero never produces a hit, so no trigger is issued.
- R7: Each group is in one of two states, active or inactive. A group becomes active when its hit rises and stays active for WINDOW_CYCLES cycles. The trigger fires when the rising hits of the two groups are sampled at clock edges at most WINDOW_CYCLES-1 edges apart. The pulse appears two cycles after the later rise is sampled. A gap of WINDOW_CYCLES edges or more gives no trigger.
- R8: The trigger is a one-cycle pulse. After a pulse, no further pulse is produced until both group windows have expired, so an overlapping burst of rises gives exactly one pulse.
- R9: In edge mode, a new edge on another enabled input of a group restarts that group's window, even if the group's earlier inputs are still high. In level mode that input adds no new hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger logic clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register offset |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| trigIn | input | NUM_INPUTS | Synchronised detector inputs |
| coincPulse | output | 1 | Coincidence trigger pulse |

## Verification
The assertions check four things on every cycle. The pulse never lasts longer than one cycle. An all-zero mask never lets a group hit through. Reads of the configuration word return the build-time fields. Reads of unmapped offsets return zero. The width of the coincidence window, the single pulse per overlapping burst, the effect of the invert bits, and the retrigger difference between level and edge stages depend on the timing between the two groups, so only the bench scenarios can show them. The bench runs a cycle model of both stage variants side by side, first on gaps of exactly WINDOW_CYCLES-1 and WINDOW_CYCLES edges, then on random masks and random input toggles.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  typedef struct packed {
    logic riseA;
    logic riseB;
  } grp_strobe_t;

  localparam logic [7:0] OFS_INVERT = 8'h24;
  localparam logic [7:0] OFS_GRP_A  = 8'h25;
  localparam logic [7:0] OFS_GRP_B  = 8'h26;
  localparam logic [7:0] OFS_CONFIG = 8'h27;

  localparam logic [3:0] STAGE_LEVEL = 4'd1;
  localparam logic [3:0] STAGE_EDGE  = 4'd2;

endpackage

// File: rtl/coinc_datapath.sv
module coinc_datapath
  import coinc_pkg::*;
#(
  parameter int NUM_INPUTS  = 32,
  parameter int NUM_OUTPUTS = 1,
  parameter bit EDGE_MODE   = 1'b0,
  parameter int ADDR_W      = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic [NUM_INPUTS-1:0] trigIn,
  output logic [NUM_INPUTS-1:0] invMask,
  output logic [NUM_INPUTS-1:0] maskA,
  output logic [NUM_INPUTS-1:0] maskB,
  output grp_strobe_t           strobe
);

  localparam int DATA_W = 32;
  localparam logic [3:0] STAGE_CODE = EDGE_MODE ? STAGE_EDGE : STAGE_LEVEL;
  localparam logic [DATA_W-1:0] CFG_WORD =
    {12'd0, STAGE_CODE, 4'd0, 4'(NUM_OUTPUTS), 2'd0, 6'(NUM_INPUTS)};

  logic [NUM_INPUTS-1:0] polarity;
  logic [NUM_INPUTS-1:0] stageOut;
  logic                  hitA, hitB;
  logic                  hitPrevA, hitPrevB;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invMask <= '0;
      maskA   <= '0;
      maskB   <= '0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_W'(OFS_INVERT): invMask <= regWdata[NUM_INPUTS-1:0];
        ADDR_W'(OFS_GRP_A):  maskA   <= regWdata[NUM_INPUTS-1:0];
        ADDR_W'(OFS_GRP_B):  maskB   <= regWdata[NUM_INPUTS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
    end else begin
      regRdata <= '0;
      if (regRd) begin
        case (regAddr)
          ADDR_W'(OFS_INVERT): regRdata <= DATA_W'(invMask);
          ADDR_W'(OFS_GRP_A):  regRdata <= DATA_W'(maskA);
          ADDR_W'(OFS_GRP_B):  regRdata <= DATA_W'(maskB);
          ADDR_W'(OFS_CONFIG): regRdata <= CFG_WORD;
          default: ;
        endcase
      end
    end
  end

  assign polarity = trigIn ^ invMask;

  // input stage variant
  generate
    if (EDGE_MODE) begin : g_edge
      logic [NUM_INPUTS-1:0] polPrev;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) polPrev <= '0;
        else       polPrev <= polarity;
      end
      assign stageOut = polarity & ~polPrev;
    end else begin : g_level
      assign stageOut = polarity;
    end
  endgenerate

  assign hitA = |(stageOut & maskA);
  assign hitB = |(stageOut & maskB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitPrevA <= 1'b0;
      hitPrevB <= 1'b0;
      strobe   <= '0;
    end else begin
      hitPrevA     <= hitA;
      hitPrevB     <= hitB;
      strobe.riseA <= hitA & ~hitPrevA;
      strobe.riseB <= hitB & ~hitPrevB;
    end
  end

endmodule

// File: rtl/coinc_ctrl.sv
module coinc_ctrl
  import coinc_pkg::*;
#(
  parameter int WINDOW_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  grp_strobe_t strobe,
  output logic        coincPulse
);

  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WINDOW_CYCLES);

  logic [1:0] rise;
  logic [1:0] active;
  logic       fired;
  logic       pulseNext;

  assign rise = {strobe.riseB, strobe.riseA};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_win
      logic [CNT_W-1:0] winCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               winCnt <= '0;
        else if (rise[g])        winCnt <= WIN_LOAD;
        else if (winCnt != '0)   winCnt <= winCnt - 1'b1;
      end
      assign active[g] = (winCnt != '0);
    end
  endgenerate

  assign pulseNext = active[0] & active[1] & ~fired;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fired      <= 1'b0;
      coincPulse <= 1'b0;
    end else begin
      coincPulse <= pulseNext;
      if (pulseNext)                   fired <= 1'b1;
      else if (active == 2'b00)        fired <= 1'b0;
    end
  end

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import coinc_pkg::*;
#(
  parameter int NUM_INPUTS    = 32,
  parameter int NUM_OUTPUTS   = 1,
  parameter bit EDGE_MODE     = 1'b0,
  parameter int WINDOW_CYCLES = 8,
  parameter int ADDR_W        = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic [NUM_INPUTS-1:0] trigIn,
  output logic                  coincPulse
);

  logic [NUM_INPUTS-1:0] invMask, maskA, maskB;
  grp_strobe_t           strobe;

  coinc_datapath #(
    .NUM_INPUTS (NUM_INPUTS),
    .NUM_OUTPUTS(NUM_OUTPUTS),
    .EDGE_MODE  (EDGE_MODE),
    .ADDR_W     (ADDR_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .trigIn  (trigIn),
    .invMask (invMask),
    .maskA   (maskA),
    .maskB   (maskB),
    .strobe  (strobe)
  );

  coinc_ctrl #(
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .coincPulse(coincPulse)
  );

endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk
  import coinc_pkg::*;
#(
  parameter int NUM_INPUTS  = 32,
  parameter int NUM_OUTPUTS = 1,
  parameter bit EDGE_MODE   = 1'b0,
  parameter int ADDR_W      = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     regAddr,
  input logic                  regRd,
  input logic [31:0]           regRdata,
  input logic [NUM_INPUTS-1:0] maskA,
  input logic [NUM_INPUTS-1:0] maskB,
  input logic                  riseA,
  input logic                  riseB,
  input logic                  coincPulse
);

  localparam logic [3:0] EXP_CODE = EDGE_MODE ? STAGE_EDGE : STAGE_LEVEL;

  logic mapped;
  assign mapped = (regAddr == ADDR_W'(OFS_INVERT)) || (regAddr == ADDR_W'(OFS_GRP_A)) ||
                  (regAddr == ADDR_W'(OFS_GRP_B))  || (regAddr == ADDR_W'(OFS_CONFIG));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    coincPulse |=> !coincPulse);

  a_r6_zero_mask_a: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskA) == '0) |-> !riseA);

  a_r6_zero_mask_b: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskB) == '0) |-> !riseB);

  a_r3_config_fields: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_W'(OFS_CONFIG)) |=>
      (regRdata[5:0] == 6'(NUM_INPUTS)) && (regRdata[11:8] == 4'(NUM_OUTPUTS)) &&
      (regRdata[19:16] == EXP_CODE) && (regRdata[31:20] == '0) &&
      (regRdata[15:12] == '0) && (regRdata[7:6] == '0));

  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !mapped) |=> (regRdata == '0));

endmodule

bind coinc_trigger coinc_trigger_chk #(
  .NUM_INPUTS (NUM_INPUTS),
  .NUM_OUTPUTS(NUM_OUTPUTS),
  .EDGE_MODE  (EDGE_MODE),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regRd     (regRd),
  .regRdata  (regRdata),
  .maskA     (maskA),
  .maskB     (maskB),
  .riseA     (strobe.riseA),
  .riseB     (strobe.riseB),
  .coincPulse(coincPulse)
);

// File: tb/coinc_trigger_bench.sv
module coinc_trigger_bench;

  localparam int N   = 32;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdLvl, rdEdg;
  logic [N-1:0] trig = '0;
  logic        pulseLvl, pulseEdg;

  int errors = 0;
  int checks = 0;
  int pcnt [2];
  logic [N-1:0] shInv = '0, shA = '0, shB = '0;

  always #5 clk = ~clk;

  coinc_trigger #(.EDGE_MODE(1'b0)) u_coinc_trigger (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(rdLvl), .trigIn(trig), .coincPulse(pulseLvl));

  coinc_trigger #(.EDGE_MODE(1'b1)) u_coinc_trigger_edge (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(rdEdg), .trigIn(trig), .coincPulse(pulseEdg));

  // reference cycle model, index 0 level stage, 1 edge stage
  logic [N-1:0] mPolPrev [2];
  logic         mHitPrevA [2], mHitPrevB [2], mRiseA [2], mRiseB [2];
  int           mCntA [2], mCntB [2];
  logic         mFired [2], mExp [2];

  function automatic logic groupHit(input logic [N-1:0] stage, input logic [N-1:0] mask);
    return |(stage & mask);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int m = 0; m < 2; m++) begin
        mPolPrev[m] = '0; mHitPrevA[m] = 0; mHitPrevB[m] = 0; mRiseA[m] = 0; mRiseB[m] = 0;
        mCntA[m] = 0; mCntB[m] = 0; mFired[m] = 0; mExp[m] = 0;
      end
    end else begin
      for (int m = 0; m < 2; m++) begin
        logic [N-1:0] pol, stg;
        logic hA, hB, actA, actB;
        pol  = trig ^ shInv;
        stg  = (m == 1) ? (pol & ~mPolPrev[m]) : pol;
        hA   = groupHit(stg, shA);
        hB   = groupHit(stg, shB);
        actA = mCntA[m] != 0;
        actB = mCntB[m] != 0;
        mExp[m] = actA && actB && !mFired[m];
        if (mExp[m]) mFired[m] = 1;
        else if (!actA && !actB) mFired[m] = 0;
        mCntA[m] = mRiseA[m] ? WIN : (mCntA[m] > 0 ? mCntA[m] - 1 : 0);
        mCntB[m] = mRiseB[m] ? WIN : (mCntB[m] > 0 ? mCntB[m] - 1 : 0);
        mRiseA[m] = hA && !mHitPrevA[m];
        mRiseB[m] = hB && !mHitPrevB[m];
        mHitPrevA[m] = hA;
        mHitPrevB[m] = hB;
        mPolPrev[m] = pol;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every cycle: pulses against the model (R7, R8)
  always @(negedge clk) begin
    if (rstN) begin
      check("R7/R8 level pulse vs model", {31'd0, pulseLvl}, {31'd0, mExp[0]});
      check("R7/R8 edge pulse vs model",  {31'd0, pulseEdg}, {31'd0, mExp[1]});
      pcnt[0] += int'(pulseLvl);
      pcnt[1] += int'(pulseEdg);
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    case (a)
      8'h24: shInv = d;
      8'h25: shA   = d;
      8'h26: shB   = d;
      default: ;
    endcase
  endtask

  task automatic regRead(input logic [7:0] a);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  // counts pulses of both variants over a scenario
  int base0, base1;
  task automatic markCounts();
    #1; base0 = pcnt[0]; base1 = pcnt[1];
  endtask
  task automatic expectCounts(input string tag, input int eLvl, input int eEdg);
    #1;
    check({tag, " level"}, 32'(pcnt[0] - base0), 32'(eLvl));
    check({tag, " edge"},  32'(pcnt[1] - base1), 32'(eEdg));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pcnt[0] = 0; pcnt[1] = 0;
    void'($urandom(32'd2718));
    waitCycles(3);
    #1 check("R1 pulse low in reset", {31'd0, pulseLvl}, 0);
    rstN = 1'b1;
    waitCycles(2);
    #1 check("R1 rdata idle after reset", rdLvl, 0);

    // register map
    regRead(8'h24); check("R1 invert resets zero", rdLvl, 0);
    regRead(8'h25); check("R1 group A resets zero", rdLvl, 0);
    regRead(8'h26); check("R1 group B resets zero", rdEdg, 0);
    regRead(8'h27);
    check("R3 config level", rdLvl, 32'h0001_0120);
    check("R3 config edge",  rdEdg, 32'h0002_0120);
    regWrite(8'h27, 32'hFFFF_FFFF);
    regRead(8'h27); check("R3 config write ignored", rdLvl, 32'h0001_0120);
    regRead(8'h30); check("R4 unmapped read", rdLvl, 0);
    regRead(8'h00); check("R4 offset zero read", rdEdg, 0);
    regWrite(8'h25, 32'hA5C3_0F01);
    regWrite(8'h26, 32'h5A3C_F0FE);
    regRead(8'h25); check("R2 group A readback", rdLvl, 32'hA5C3_0F01);
    regRead(8'h26); check("R2 group B readback", rdEdg, 32'h5A3C_F0FE);
    waitCycles(1); #1 check("R2 rdata zero without read", rdLvl, 0);

    // window width: gap WIN-1 fires, gap WIN does not
    regWrite(8'h25, 32'h1); regWrite(8'h26, 32'h2);
    waitCycles(20);
    markCounts();
    trig[0] = 1'b1; waitCycles(WIN - 1); trig[1] = 1'b1; waitCycles(20);
    expectCounts("R7 gap WIN-1 fires", 1, 1);
    trig = '0; waitCycles(20);
    markCounts();
    trig[0] = 1'b1; waitCycles(WIN); trig[1] = 1'b1; waitCycles(20);
    expectCounts("R7 gap WIN silent", 0, 0);
    trig = '0; waitCycles(20);

    // zero mask on group B
    regWrite(8'h26, 32'h0);
    markCounts();
    trig = '1; waitCycles(20);
    expectCounts("R6 zero mask no trigger", 0, 0);
    trig = '0; waitCycles(20);
    regWrite(8'h26, 32'h2);

    // overlapping burst gives one pulse
    waitCycles(20);
    markCounts();
    for (int k = 0; k < 6; k++) begin
      trig[1:0] = 2'b11; waitCycles(2);
      trig[1:0] = 2'b00; waitCycles(2);
    end
    waitCycles(20);
    expectCounts("R8 burst single pulse", 1, 1);

    // inversion: falling raw input is the hit
    regWrite(8'h24, 32'h1);
    trig[0] = 1'b1; waitCycles(20);
    markCounts();
    trig[0] = 1'b0; trig[1] = 1'b1; waitCycles(20);
    expectCounts("R5 inverted falling hit", 1, 1);
    trig = '0;
    regWrite(8'h24, 32'h0);
    waitCycles(20);

    // retrigger by a second input of group A
    regWrite(8'h25, 32'h3); regWrite(8'h26, 32'h4);
    waitCycles(20);
    markCounts();
    trig[0] = 1'b1; waitCycles(10); trig[1] = 1'b1; waitCycles(2); trig[2] = 1'b1;
    waitCycles(20);
    expectCounts("R9 edge retrigger", 0, 1);
    trig = '0; waitCycles(20);

    // random phase against the model
    for (int blk = 0; blk < 8; blk++) begin
      regWrite(8'h24, ($urandom % 4 == 0) ? $urandom : 32'h0);
      regWrite(8'h25, ($urandom % 6 == 0) ? 32'h0 : ($urandom & $urandom));
      regWrite(8'h26, ($urandom % 6 == 0) ? 32'h0 : ($urandom & $urandom));
      for (int c = 0; c < 500; c++) begin
        @(negedge clk);
        if ($urandom % 3 == 0) trig[$urandom % N] ^= 1'b1;
        if ($urandom % 40 == 0) trig = '0;
      end
    end

    waitCycles(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule